// File: doc/BRIEF.md
# Receive-Link Reset Sequencer

This controller sits on the user side of a multi-lane serial receive link. It brings the link up after power-on, and again whenever a reset is requested. It owns three reset lines: the link-layer reset (active low), the configuration-bus reset (active low) and the transceiver-reconfiguration reset (active high). It releases them in a fixed order. Each step waits on a feedback signal: core PLL lock, a configuration-done handshake, a channel-reset acknowledge, a MAC out-of-reset status and finally link-valid.

In deterministic-latency mode (`subclass1_en` high), the sequencer watches for a SYSREF pulse once the MAC is out of reset. If none arrives in time, it asks the clock generator for one with a single-cycle request. Every wait that depends on the outside world has a timeout. When a timeout expires, the block moves to an error state that holds all resets asserted until a new start request arrives.

The asynchronous inputs (PLL lock, acknowledge, out-of-reset) each pass through a two-flop synchronizer before the state machine uses them. All reset outputs come straight from flip-flops.

Top module: `rx_link_rst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first state after it, outputs are `link_rst_n`=0, `cfg_rst_n`=0, `reconf_rst`=1, `sysref_req`=0, `done`=0 and `error`=0.
- R2: Whenever `reconf_rst` is 1 or `cfg_rst_n` is 0, `link_rst_n` is 0. `link_rst_n` may be 0 while the other two are released.
- R3: All three resets stay asserted until `pll_lock` is seen high through its two-flop synchronizer. Then `reconf_rst` and `cfg_rst_n` are released together, while `link_rst_n` stays 0.
- R4: `link_rst_n` is released only after `cfg_done` is 1 and the synchronized `rst_ack_n` is 0. The acknowledge is active low: 0 means all channels are held in reset, and 1 is its idle level.
- R5: After the link reset is released, the sequence does not continue until the synchronized `out_of_rst` is 1. `done` stays 0 while it is low, even if `link_valid` is high.
- R6: With `subclass1_en`=1, if no `sysref_seen` pulse arrives within SYSREF_WAIT cycles of entering the SYSREF wait, exactly one single-cycle `sysref_req` is issued. If a pulse arrives, or `subclass1_en`=0, no request is issued.
- R7: `done` rises only after `link_valid` has been high. While `done` is 1, `link_rst_n` is 1 and `error` is 0.
- R8: A `start` pulse while `done` is 1 is held pending until the synchronized `rst_ack_n` is 1. Then `link_rst_n` goes to 0 alone, `cfg_rst_n` stays 1, `reconf_rst` stays 0, and `done` falls.
- R9: The link-only reset is complete once the synchronized `rst_ack_n` is 0 and the synchronized `out_of_rst` is 0. Only then is `link_rst_n` released again.
- R10: If a wait state other than the SYSREF wait and the operational state lasts TMO_CYC cycles, the block enters an error state: `error`=1, `link_rst_n`=0, `cfg_rst_n`=0, `reconf_rst`=1. It stays there until `start`, which restarts from the PLL wait with `error`=0.
- R11: `sysref_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start | input | 1 | Reset/bring-up request pulse |
| subclass1_en | input | 1 | Deterministic-latency mode, enables the SYSREF check |
| pll_lock | input | 1 | Core PLL lock, asynchronous |
| cfg_done | input | 1 | Configuration phase finished, link domain |
| rst_ack_n | input | 1 | Channel-reset acknowledge, active low, asynchronous |
| out_of_rst | input | 1 | MAC out-of-reset status, asynchronous |
| sysref_seen | input | 1 | SYSREF pulse observed, link domain |
| link_valid | input | 1 | Lane alignment and deskew complete |
| link_rst_n | output | 1 | Link/MAC reset, active low |
| cfg_rst_n | output | 1 | Configuration-bus reset, active low |
| reconf_rst | output | 1 | Transceiver-reconfiguration reset, active high |
| sysref_req | output | 1 | Single-cycle SYSREF request to the clock generator |
| done | output | 1 | Subsystem operational |
| error | output | 1 | Timeout error, all resets held |

## Verification
A wrong state shows up at the ports as a wrong reset combination: a reset line released out of order, or `done` high without a prior `link_valid`. Because the outputs are decoded from the next state and registered, these appear on the same edge the state changes. Synchronizer faults shift every release by whole cycles, so the checks sample a few cycles after each stimulus. A broken timer shows up either as a missing `error` or a missing `sysref_req`, or as one that fires early while a valid feedback is still pending.

// File: rtl/rls_pkg.sv
package rls_pkg;
   typedef enum logic [3:0] {
      ST_PLL    = 4'd0,
      ST_CFG    = 4'd1,
      ST_ACK    = 4'd2,
      ST_OOR    = 4'd3,
      ST_SREF   = 4'd4,
      ST_VALID  = 4'd5,
      ST_UP     = 4'd6,
      ST_DRAIN  = 4'd7,
      ST_ERR    = 4'd8
   } seq_st_e;

   typedef struct packed {
      logic link_rst_n;
      logic cfg_rst_n;
      logic reconf_rst;
      logic done;
      logic error;
   } seq_out_t;
endpackage

// File: rtl/rls_sync.sv
module rls_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic [WIDTH-1:0] init,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rls_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= init;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= init;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rls_timer.sv
module rls_timer #(
   parameter int TMO_CYC     = 1024,
   parameter int SYSREF_WAIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tmo_hit,
   output logic sref_hit
);
   localparam int MAXV = (TMO_CYC > SYSREF_WAIT) ? TMO_CYC : SYSREF_WAIT;
   localparam int CW   = $clog2(MAXV + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clr)                 cnt_q <= '0;
      else if (cnt_q != CW'(MAXV))  cnt_q <= cnt_q + 1'b1;
   end

   assign tmo_hit  = (cnt_q == CW'(TMO_CYC - 1));
   assign sref_hit = (cnt_q == CW'(SYSREF_WAIT - 1));
endmodule

// File: rtl/rls_fsm.sv
module rls_fsm
   import rls_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     subclass1_en,
   input  logic     pll_s,
   input  logic     cfg_done,
   input  logic     ack_n_s,
   input  logic     oor_s,
   input  logic     sysref_seen,
   input  logic     link_valid,
   input  logic     tmo_hit,
   input  logic     sref_hit,
   output logic     tmr_clr,
   output seq_out_t outs,
   output logic     sysref_req
);
   seq_st_e  st_q, st_d;
   logic     pend_q;
   logic     sref_fire;
   seq_out_t dec;

   always_comb begin
      st_d      = st_q;
      sref_fire = 1'b0;
      unique case (st_q)
         ST_PLL:   if (pll_s) st_d = ST_CFG;
                   else if (tmo_hit) st_d = ST_ERR;
         ST_CFG:   if (cfg_done) st_d = ST_ACK;
                   else if (tmo_hit) st_d = ST_ERR;
         ST_ACK:   if (!ack_n_s) st_d = ST_OOR;
                   else if (tmo_hit) st_d = ST_ERR;
         ST_OOR:   if (oor_s) st_d = subclass1_en ? ST_SREF : ST_VALID;
                   else if (tmo_hit) st_d = ST_ERR;
         ST_SREF:  if (sysref_seen) st_d = ST_VALID;
                   else if (sref_hit) begin
                      st_d      = ST_VALID;
                      sref_fire = 1'b1;
                   end
         ST_VALID: if (link_valid) st_d = ST_UP;
                   else if (tmo_hit) st_d = ST_ERR;
         ST_UP:    if ((start || pend_q) && ack_n_s) st_d = ST_DRAIN;
         ST_DRAIN: if (!ack_n_s && !oor_s) st_d = ST_ACK;
                   else if (tmo_hit) st_d = ST_ERR;
         ST_ERR:   if (start) st_d = ST_PLL;
         default:  st_d = ST_ERR;
      endcase
   end

   assign tmr_clr = (st_d != st_q);

   always_comb begin
      dec.link_rst_n = (st_d == ST_OOR) || (st_d == ST_SREF) ||
                       (st_d == ST_VALID) || (st_d == ST_UP);
      dec.cfg_rst_n  = !((st_d == ST_PLL) || (st_d == ST_ERR));
      dec.reconf_rst = (st_d == ST_PLL) || (st_d == ST_ERR);
      dec.done       = (st_d == ST_UP);
      dec.error      = (st_d == ST_ERR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_PLL;
         pend_q     <= 1'b0;
         sysref_req <= 1'b0;
         outs       <= '{link_rst_n: 1'b0, cfg_rst_n: 1'b0, reconf_rst: 1'b1,
                         done: 1'b0, error: 1'b0};
      end else begin
         st_q       <= st_d;
         sysref_req <= sref_fire;
         outs       <= dec;
         if (st_q == ST_UP && st_d == ST_UP) pend_q <= pend_q | start;
         else                                pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_link_rst_seq.sv
module rx_link_rst_seq
   import rls_pkg::*;
#(
   parameter int TMO_CYC     = 1024,
   parameter int SYSREF_WAIT = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic subclass1_en,
   input  logic pll_lock,
   input  logic cfg_done,
   input  logic rst_ack_n,
   input  logic out_of_rst,
   input  logic sysref_seen,
   input  logic link_valid,
   output logic link_rst_n,
   output logic cfg_rst_n,
   output logic reconf_rst,
   output logic sysref_req,
   output logic done,
   output logic error
);
   if (TMO_CYC < 4) begin : g_bad_tmo
      $error("rx_link_rst_seq: TMO_CYC must be at least 4");
   end
   if (SYSREF_WAIT < 2 || SYSREF_WAIT >= TMO_CYC) begin : g_bad_sref
      $error("rx_link_rst_seq: SYSREF_WAIT must lie in [2, TMO_CYC)");
   end

   localparam int NSYNC = 3;

   logic [NSYNC-1:0] raw, synced;
   logic             tmr_clr, tmo_hit, sref_hit;
   seq_out_t         outs;

   assign raw = {out_of_rst, rst_ack_n, pll_lock};

   rls_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .init (3'b010),
      .q    (synced)
   );

   rls_timer #(.TMO_CYC(TMO_CYC), .SYSREF_WAIT(SYSREF_WAIT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .tmo_hit (tmo_hit),
      .sref_hit(sref_hit)
   );

   rls_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .subclass1_en(subclass1_en),
      .pll_s       (synced[0]),
      .cfg_done    (cfg_done),
      .ack_n_s     (synced[1]),
      .oor_s       (synced[2]),
      .sysref_seen (sysref_seen),
      .link_valid  (link_valid),
      .tmo_hit     (tmo_hit),
      .sref_hit    (sref_hit),
      .tmr_clr     (tmr_clr),
      .outs        (outs),
      .sysref_req  (sysref_req)
   );

   assign link_rst_n = outs.link_rst_n;
   assign cfg_rst_n  = outs.cfg_rst_n;
   assign reconf_rst = outs.reconf_rst;
   assign done       = outs.done;
   assign error      = outs.error;
endmodule

// File: rtl/rx_link_rst_seq_chk.sv
module rx_link_rst_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic pll_lock,
   input logic link_valid,
   input logic link_rst_n,
   input logic cfg_rst_n,
   input logic reconf_rst,
   input logic sysref_req,
   input logic done,
   input logic error
);
   // R2
   reset_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reconf_rst || !cfg_rst_n) |-> !link_rst_n);

   // R3
   lock_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reconf_rst) |-> $past(pll_lock, 2));

   // R7
   done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(link_valid));

   // R7
   done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (link_rst_n && !error));

   // R10
   error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (!link_rst_n && !cfg_rst_n && reconf_rst));

   // R11
   sysref_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sysref_req |=> !sysref_req);
endmodule

bind rx_link_rst_seq rx_link_rst_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pll_lock  (pll_lock),
   .link_valid(link_valid),
   .link_rst_n(link_rst_n),
   .cfg_rst_n (cfg_rst_n),
   .reconf_rst(reconf_rst),
   .sysref_req(sysref_req),
   .done      (done),
   .error     (error)
);

// File: tb/sim_rx_link_rst_seq.sv
`timescale 1ns/1ps
module sim_rx_link_rst_seq;
   localparam int TMO  = 60;
   localparam int SREF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, subclass1_en = 1'b0, pll_lock = 1'b0, cfg_done = 1'b0;
   logic rst_ack_n = 1'b1, out_of_rst = 1'b0, sysref_seen = 1'b0, link_valid = 1'b0;
   logic link_rst_n, cfg_rst_n, reconf_rst, sysref_req, done, error;

   always #5 clk = ~clk;

   rx_link_rst_seq #(.TMO_CYC(TMO), .SYSREF_WAIT(SREF)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .subclass1_en(subclass1_en),
      .pll_lock(pll_lock), .cfg_done(cfg_done), .rst_ack_n(rst_ack_n),
      .out_of_rst(out_of_rst), .sysref_seen(sysref_seen), .link_valid(link_valid),
      .link_rst_n(link_rst_n), .cfg_rst_n(cfg_rst_n), .reconf_rst(reconf_rst),
      .sysref_req(sysref_req), .done(done), .error(error));

   typedef struct {
      logic [5:0] v;
      string      tag;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int   checks = 0, failures = 0, sref_cnt = 0;
   bit   finished = 1'b0;

   // vector order: link_rst_n cfg_rst_n reconf_rst sysref_req done error
   always @(negedge clk) begin
      while (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if ({link_rst_n, cfg_rst_n, reconf_rst, sysref_req, done, error} !== e.v) begin
            failures++;
            $display("FAIL %s: got %b expected %b", e.tag,
                     {link_rst_n, cfg_rst_n, reconf_rst, sysref_req, done, error}, e.v);
         end
      end
   end

   always @(posedge clk) if (rst_n && sysref_req) sref_cnt++;

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input logic [5:0] v, input string tag);
      q.push_back('{v: v, tag: tag});
   endtask

   task automatic check_cnt(input int got, input int exp, input string tag);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic pulse_start();
      start = 1'b1; cyc(1); start = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(3);
      expect_out(6'b001000, "R1 during reset"); cyc(1);
      rst_n = 1'b1;
      cyc(1); expect_out(6'b001000, "R1 after reset"); cyc(1);
      cyc(10); expect_out(6'b001000, "R3 hold without lock"); cyc(1);
      pll_lock = 1'b1;
      cyc(4); expect_out(6'b010000, "R3 release after lock"); cyc(1);
      cfg_done = 1'b1;
      cyc(5); expect_out(6'b010000, "R4 ack idle keeps link reset"); cyc(1);
      rst_ack_n = 1'b0;
      cyc(4); expect_out(6'b110000, "R4 link released on ack"); cyc(1);
      link_valid = 1'b1;
      cyc(5); expect_out(6'b110000, "R5 no done before out_of_rst"); cyc(1);
      out_of_rst = 1'b1;
      cyc(6); expect_out(6'b110010, "R5 R7 operational"); cyc(1);
      check_cnt(sref_cnt, 0, "R6 no request in subclass 0");

      pulse_start();
      cyc(5); expect_out(6'b110010, "R8 start deferred while ack low"); cyc(1);
      rst_ack_n = 1'b1;
      cyc(4); expect_out(6'b010000, "R8 link-only reset"); cyc(1);
      rst_ack_n = 1'b0;
      cyc(5); expect_out(6'b010000, "R9 wait for out_of_rst low"); cyc(1);
      subclass1_en = 1'b1;
      out_of_rst = 1'b0;
      cyc(4); expect_out(6'b110000, "R9 link released after drain"); cyc(1);
      out_of_rst = 1'b1;
      cyc(25); expect_out(6'b110010, "R6 operational after request"); cyc(1);
      check_cnt(sref_cnt, 1, "R6 one request without SYSREF");

      pulse_start();
      rst_ack_n = 1'b1;
      cyc(4); expect_out(6'b010000, "R8 second link reset"); cyc(1);
      rst_ack_n = 1'b0; out_of_rst = 1'b0;
      cyc(5); expect_out(6'b110000, "R9 second release"); cyc(1);
      out_of_rst = 1'b1;
      cyc(3); sysref_seen = 1'b1; cyc(2); sysref_seen = 1'b0;
      cyc(20); expect_out(6'b110010, "R6 operational with SYSREF"); cyc(1);
      check_cnt(sref_cnt, 1, "R6 no request when SYSREF seen");

      rst_ack_n = 1'b1;
      cyc(3);
      pulse_start();
      cyc(TMO + 10); expect_out(6'b001001, "R10 timeout error"); cyc(1);
      cyc(5); expect_out(6'b001001, "R10 error held"); cyc(1);
      pulse_start();
      cyc(5); expect_out(6'b010000, "R10 restart clears error"); cyc(1);
      cyc(2);
      finish_run();
   end
endmodule